// File: doc/BRIEF.md
# Converter Control Word and Calibration Step Sequencer

This block holds the write-only control word of a data converter and turns it into activity. A host writes a 14-bit word to one of four addresses. Only the control address, where both address bits are 1, reaches the word. The word sets the power-management code, selects the read-back register and selects the interface mode. It can also launch a single conversion or a calibration.

A calibration is a short, ordered list of steps. Each step is a DAC trim, a gain trim or an offset trim. Gain and offset steps are internal or system steps. The sequencer issues each step as a one-cycle command and then waits for the step-done input before it moves on. The start bits and the interface-mode bit clear themselves when their operation ends. When no calibration is requested, the two type bits instead address a calibration-coefficient register.

The controller has five states. `S_IDLE` waits for a pending start bit, and a pending calibration wins over a pending conversion. `S_CAL_ISSUE` pulses one step command and always moves to `S_CAL_WAIT`. `S_CAL_WAIT` leaves on step-done: it returns to `S_CAL_ISSUE` with the next step, or to `S_IDLE` after the last step. `S_CONV_ISSUE` pulses the conversion start and always moves to `S_CONV_WAIT`. `S_CONV_WAIT` returns to `S_IDLE` on conversion-done.

Top module: `adc_ctrl_seq`

## Requirements
- R1: A write changes the control word only when `wr_addr` is 2'b11. A write to any other address leaves every output unchanged.
- R2: After reset the control word is all zeros, `busy`, `wr_err`, `step_cmd` and `conv_start` are 0, and `coef_sel_valid` is 1.
- R3: Field positions in `wr_data` and `ctrl_word` are as follows. Power code is bits 9:8 (`pwr_mode`). Read select is bits 7:6 (`rd_sel`). Interface mode is bit 5 (`if_mode1`, 1 = mode 1). Conversion start is bit 4. Calibration mode is bit 3 (1 = system). Calibration type is bits 2:1. Calibration start is bit 0. Each of these appears on `ctrl_word` one cycle after the write.
- R4: Writing bit 4 as 1 while idle gives exactly one `conv_start` pulse. `busy` then stays high, and bit 4 stays 1, until `conv_done` is seen after that pulse. At that point both drop.
- R5: `read_done` clears `if_mode1`. If a control write arrives in the same cycle, the written value wins.
- R6: Writing bit 0 as 1 while idle starts a step sequence chosen by the type bits. Type 00 runs DAC, gain, offset. Type 01 runs gain, offset. Type 10 runs offset only. Type 11 runs gain only. Step codes on `step_code` are DAC = 01, gain = 10 and offset = 11. `step_sys` equals the mode bit for gain and offset steps and is 0 for the DAC step. The next step is issued only after `step_done`.
- R7: Bit 0 returns to 0, and `busy` falls, on the `step_done` of the last step of the sequence.
- R8: `coef_sel` always shows bits 2:1. `coef_sel_valid` is 1 exactly when bit 0 is 0.
- R9: While `busy` is high, a write leaves bits 4 and 0 unchanged, whatever it writes there. Its other fields are still taken.
- R10: If one write sets both bit 4 and bit 0, the whole calibration runs first. The single `conv_start` pulse follows only after it.
- R11: A control write with any of bits 13:10 nonzero sets `wr_err`, which stays set until reset. The rest of that write is accepted, and `ctrl_word[13:10]` reads 0.
- R12: `step_cmd` and `conv_start` are single-cycle pulses and are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register address; 2'b11 is the control word |
| wr_data | input | 14 | Write data |
| read_done | input | 1 | End of a read cycle |
| conv_done | input | 1 | Conversion finished |
| step_done | input | 1 | Current calibration step finished |
| conv_start | output | 1 | One-cycle conversion launch |
| step_cmd | output | 1 | One-cycle calibration step command |
| step_code | output | 2 | Step kind, valid with `step_cmd` |
| step_sys | output | 1 | System (1) or internal (0) step, valid with `step_cmd` |
| busy | output | 1 | Conversion or calibration pending or running |
| rd_sel | output | 2 | Read-back register select |
| if_mode1 | output | 1 | Interface mode 1 selected |
| pwr_mode | output | 2 | Power-management code |
| coef_sel | output | 2 | Calibration-coefficient register address |
| coef_sel_valid | output | 1 | `coef_sel` is an address (no calibration requested) |
| wr_err | output | 1 | Sticky reserved-bit write error |
| ctrl_word | output | 14 | Current control word |

## Verification
The bench sweeps all eight mode/type combinations and compares each step's code and system flag with the ordered list. A sequencer that ended one step early or late, or that mislabelled the DAC step as a system step, would show a wrong pulse or a missing one. It also checks the write that sets both start bits: a design that launched the conversion first, or dropped it, would pulse `conv_start` at the wrong point. Writes made while busy try both to set and to clear the start bits. A design that let them through would start a second operation or strand the first. Same-cycle read-done and write, and off-address writes, expose a wrong priority or a bad address decode.

// File: rtl/adc_ctrl_pkg.sv
package adc_ctrl_pkg;

    localparam int POS_STCAL = 0;
    localparam int POS_CTYPE = 1;
    localparam int POS_CMODE = 3;
    localparam int POS_CVST  = 4;
    localparam int POS_IMODE = 5;
    localparam int POS_RSEL  = 6;
    localparam int POS_PM    = 8;
    localparam int POS_RSV   = 10;

    typedef enum logic [1:0] {
        STEP_NONE = 2'b00,
        STEP_DAC  = 2'b01,
        STEP_GAIN = 2'b10,
        STEP_OFFS = 2'b11
    } step_e;

    typedef enum logic [2:0] {
        S_IDLE,
        S_CAL_ISSUE,
        S_CAL_WAIT,
        S_CONV_ISSUE,
        S_CONV_WAIT
    } seq_state_e;

    typedef struct packed {
        logic [1:0] pm;
        logic [1:0] rsel;
        logic       imode;
        logic       cvst;
        logic       cmode;
        logic [1:0] ctype;
        logic       stcal;
    } ctrl_fields_t;

    localparam int FIELDS_W = $bits(ctrl_fields_t);

endpackage

// File: rtl/adc_ctrl_reg.sv
module adc_ctrl_reg
    import adc_ctrl_pkg::*;
#(
    parameter int                ADDR_W    = 2,
    parameter int                DATA_W    = 14,
    parameter logic [ADDR_W-1:0] CTRL_ADDR = '1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              busy,
    input  logic              read_done,
    input  logic              conv_fin,
    input  logic              cal_fin,
    output ctrl_fields_t      fields,
    output logic              wr_err
);

    localparam int RSV_W = DATA_W - POS_RSV;

    ctrl_fields_t cur_q, cur_d;
    logic         err_q;
    logic         wr_hit;
    logic         rsv_bad;

    assign wr_hit  = wr_en && (wr_addr == CTRL_ADDR);
    assign rsv_bad = |wr_data[POS_RSV +: RSV_W];

    always_comb begin
        cur_d = cur_q;
        if (read_done) cur_d.imode = 1'b0;
        if (conv_fin)  cur_d.cvst  = 1'b0;
        if (cal_fin)   cur_d.stcal = 1'b0;
        if (wr_hit) begin
            cur_d.pm    = wr_data[POS_PM +: 2];
            cur_d.rsel  = wr_data[POS_RSEL +: 2];
            cur_d.imode = wr_data[POS_IMODE];
            cur_d.cmode = wr_data[POS_CMODE];
            cur_d.ctype = wr_data[POS_CTYPE +: 2];
            if (!busy) begin
                cur_d.cvst  = wr_data[POS_CVST];
                cur_d.stcal = wr_data[POS_STCAL];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_q <= '0;
            err_q <= 1'b0;
        end else begin
            cur_q <= cur_d;
            err_q <= err_q | (wr_hit && rsv_bad);
        end
    end

    assign fields = cur_q;
    assign wr_err = err_q;

endmodule

// File: rtl/adc_step_plan.sv
module adc_step_plan
    import adc_ctrl_pkg::*;
(
    input  logic [1:0] ctype,
    input  step_e      cur_step,
    output step_e      first_step,
    output step_e      next_step,
    output logic       is_last
);

    always_comb begin
        unique case (ctype)
            2'b00:   first_step = STEP_DAC;
            2'b01:   first_step = STEP_GAIN;
            2'b10:   first_step = STEP_OFFS;
            default: first_step = STEP_GAIN;
        endcase
    end

    always_comb begin
        next_step = STEP_NONE;
        is_last   = 1'b1;
        unique case (cur_step)
            STEP_DAC: begin
                next_step = STEP_GAIN;
                is_last   = 1'b0;
            end
            STEP_GAIN: begin
                next_step = STEP_OFFS;
                is_last   = (ctype == 2'b11);
            end
            default: begin
                next_step = STEP_NONE;
                is_last   = 1'b1;
            end
        endcase
    end

endmodule

// File: rtl/adc_cal_fsm.sv
module adc_cal_fsm
    import adc_ctrl_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       stcal,
    input  logic       cvst,
    input  logic       cmode,
    input  logic [1:0] ctype,
    input  logic       step_done,
    input  logic       conv_done,
    output logic       step_cmd,
    output logic [1:0] step_code,
    output logic       step_sys,
    output logic       conv_start,
    output logic       cal_fin,
    output logic       conv_fin,
    output logic       active
);

    seq_state_e state_q, state_d;
    step_e      step_q, step_d;
    logic       mode_q, mode_d;
    logic [1:0] type_q, type_d;

    logic [1:0] plan_type;
    step_e      plan_first;
    step_e      plan_next;
    logic       plan_last;

    assign plan_type = (state_q == S_IDLE) ? ctype : type_q;

    adc_step_plan u_plan (
        .ctype      (plan_type),
        .cur_step   (step_q),
        .first_step (plan_first),
        .next_step  (plan_next),
        .is_last    (plan_last)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= S_IDLE;
            step_q  <= STEP_NONE;
            mode_q  <= 1'b0;
            type_q  <= 2'b00;
        end else begin
            state_q <= state_d;
            step_q  <= step_d;
            mode_q  <= mode_d;
            type_q  <= type_d;
        end
    end

    always_comb begin
        state_d = state_q;
        step_d  = step_q;
        mode_d  = mode_q;
        type_d  = type_q;
        unique case (state_q)
            S_IDLE: begin
                if (stcal) begin
                    state_d = S_CAL_ISSUE;
                    step_d  = plan_first;
                    mode_d  = cmode;
                    type_d  = ctype;
                end else if (cvst) begin
                    state_d = S_CONV_ISSUE;
                end
            end
            S_CAL_ISSUE: state_d = S_CAL_WAIT;
            S_CAL_WAIT: begin
                if (step_done) begin
                    if (plan_last) begin
                        state_d = S_IDLE;
                        step_d  = STEP_NONE;
                    end else begin
                        state_d = S_CAL_ISSUE;
                        step_d  = plan_next;
                    end
                end
            end
            S_CONV_ISSUE: state_d = S_CONV_WAIT;
            S_CONV_WAIT: begin
                if (conv_done) state_d = S_IDLE;
            end
            default: state_d = S_IDLE;
        endcase
    end

    always_comb begin
        step_cmd   = (state_q == S_CAL_ISSUE);
        step_code  = step_cmd ? step_q : STEP_NONE;
        step_sys   = step_cmd && mode_q && (step_q != STEP_DAC);
        conv_start = (state_q == S_CONV_ISSUE);
        cal_fin    = (state_q == S_CAL_WAIT) && step_done && plan_last;
        conv_fin   = (state_q == S_CONV_WAIT) && conv_done;
        active     = (state_q != S_IDLE);
    end

endmodule

// File: rtl/adc_ctrl_seq.sv
module adc_ctrl_seq
    import adc_ctrl_pkg::*;
#(
    parameter int                ADDR_W    = 2,
    parameter int                DATA_W    = 14,
    parameter logic [ADDR_W-1:0] CTRL_ADDR = '1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              read_done,
    input  logic              conv_done,
    input  logic              step_done,
    output logic              conv_start,
    output logic              step_cmd,
    output logic [1:0]        step_code,
    output logic              step_sys,
    output logic              busy,
    output logic [1:0]        rd_sel,
    output logic              if_mode1,
    output logic [1:0]        pwr_mode,
    output logic [1:0]        coef_sel,
    output logic              coef_sel_valid,
    output logic              wr_err,
    output logic [DATA_W-1:0] ctrl_word
);

    ctrl_fields_t fields;
    logic         cal_fin;
    logic         conv_fin;
    logic         active;

    adc_ctrl_reg #(
        .ADDR_W    (ADDR_W),
        .DATA_W    (DATA_W),
        .CTRL_ADDR (CTRL_ADDR)
    ) u_reg (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_en),
        .wr_addr   (wr_addr),
        .wr_data   (wr_data),
        .busy      (busy),
        .read_done (read_done),
        .conv_fin  (conv_fin),
        .cal_fin   (cal_fin),
        .fields    (fields),
        .wr_err    (wr_err)
    );

    adc_cal_fsm u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .stcal      (fields.stcal),
        .cvst       (fields.cvst),
        .cmode      (fields.cmode),
        .ctype      (fields.ctype),
        .step_done  (step_done),
        .conv_done  (conv_done),
        .step_cmd   (step_cmd),
        .step_code  (step_code),
        .step_sys   (step_sys),
        .conv_start (conv_start),
        .cal_fin    (cal_fin),
        .conv_fin   (conv_fin),
        .active     (active)
    );

    assign busy           = active | fields.stcal | fields.cvst;
    assign rd_sel         = fields.rsel;
    assign if_mode1       = fields.imode;
    assign pwr_mode       = fields.pm;
    assign coef_sel       = fields.ctype;
    assign coef_sel_valid = ~fields.stcal;
    assign ctrl_word      = {{(DATA_W - FIELDS_W){1'b0}}, fields};

endmodule

// File: rtl/adc_ctrl_seq_chk.sv
module adc_ctrl_seq_chk #(
    parameter int                ADDR_W    = 2,
    parameter int                DATA_W    = 14,
    parameter logic [ADDR_W-1:0] CTRL_ADDR = '1
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wr_en,
    input logic [ADDR_W-1:0] wr_addr,
    input logic              read_done,
    input logic              conv_start,
    input logic              step_cmd,
    input logic              busy,
    input logic              if_mode1,
    input logic              wr_err,
    input logic [DATA_W-1:0] ctrl_word
);

    assert_cmd_exclusive_R12: assert property (@(posedge clk) disable iff (!rst_n)
        !(step_cmd && conv_start));

    assert_step_pulse_R12: assert property (@(posedge clk) disable iff (!rst_n)
        step_cmd |=> !step_cmd);

    assert_conv_holds_busy_R4: assert property (@(posedge clk) disable iff (!rst_n)
        conv_start |=> (!conv_start && busy));

    assert_step_while_busy_R6: assert property (@(posedge clk) disable iff (!rst_n)
        step_cmd |-> busy);

    assert_offaddr_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr != CTRL_ADDR && !busy && !read_done) |=> $stable(ctrl_word));

    assert_err_sticky_R11: assert property (@(posedge clk) disable iff (!rst_n)
        wr_err |=> wr_err);

    assert_readdone_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (read_done && !wr_en) |=> !if_mode1);

endmodule

bind adc_ctrl_seq adc_ctrl_seq_chk #(
    .ADDR_W    (ADDR_W),
    .DATA_W    (DATA_W),
    .CTRL_ADDR (CTRL_ADDR)
) u_chk (.*);

// File: tb/adc_ctrl_seq_bench.sv
`timescale 1ns/1ps
module adc_ctrl_seq_bench;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        wr_en;
    logic [1:0]  wr_addr;
    logic [13:0] wr_data;
    logic        read_done, conv_done, step_done;
    logic        conv_start, step_cmd, step_sys, busy;
    logic [1:0]  step_code, rd_sel, pwr_mode, coef_sel;
    logic        if_mode1, coef_sel_valid, wr_err;
    logic [13:0] ctrl_word;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 1'b0;

    always #2 clk = ~clk;

    adc_ctrl_seq u_adc_ctrl_seq (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .read_done(read_done), .conv_done(conv_done), .step_done(step_done),
        .conv_start(conv_start), .step_cmd(step_cmd), .step_code(step_code),
        .step_sys(step_sys), .busy(busy), .rd_sel(rd_sel), .if_mode1(if_mode1),
        .pwr_mode(pwr_mode), .coef_sel(coef_sel), .coef_sel_valid(coef_sel_valid),
        .wr_err(wr_err), .ctrl_word(ctrl_word)
    );

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic check(string req, int act, int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic write(logic [1:0] a, logic [13:0] d);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        tick();
        wr_en = 1'b0;
    endtask

    task automatic pulse_step_done();
        step_done = 1'b1; tick(); step_done = 1'b0;
    endtask

    task automatic pulse_conv_done();
        conv_done = 1'b1; tick(); conv_done = 1'b0;
    endtask

    task automatic wait_step(output bit seen);
        seen = 1'b0;
        for (int k = 0; k < 16 && !seen; k++) begin
            if (step_cmd) seen = 1'b1;
            else tick();
        end
    endtask

    task automatic wait_conv(output bit seen);
        seen = 1'b0;
        for (int k = 0; k < 16 && !seen; k++) begin
            if (conv_start) seen = 1'b1;
            else tick();
        end
    endtask

    function automatic int exp_len(int ty);
        return (ty == 0) ? 3 : (ty == 1) ? 2 : 1;
    endfunction

    function automatic int exp_code(int ty, int idx);
        int base;
        base = (ty == 0) ? 1 : (ty == 1) ? 2 : (ty == 2) ? 3 : 2;
        return (ty == 3) ? 2 : base + idx;
    endfunction

    task automatic run_cal(int md, int ty, bit with_conv);
        bit seen;
        int code;
        write(2'b11, 14'((md << 3) | (ty << 1) | 1 | (with_conv ? 16 : 0)));
        check("R8 valid low during cal", coef_sel_valid, 0);
        check("R6 busy after start", busy, 1);
        for (int i = 0; i < exp_len(ty); i++) begin
            wait_step(seen);
            check("R6 step issued", seen, 1);
            code = exp_code(ty, i);
            check("R6 step code", step_code, code);
            check("R6 step sys flag", step_sys, (code == 1) ? 0 : md);
            check("R12 no conv with step", conv_start, 0);
            tick();
            check("R12 step one cycle", step_cmd, 0);
            tick(); tick();
            check("R6 waits for done", step_cmd, 0);
            check("R7 start bit held", ctrl_word[0], 1);
            pulse_step_done();
        end
        check("R7 cal bit cleared", ctrl_word[0], 0);
        check("R8 valid after cal", coef_sel_valid, 1);
        if (with_conv) begin
            check("R10 busy kept for conv", busy, 1);
            wait_conv(seen);
            check("R10 conv after cal", seen, 1);
            check("R10 no further step", step_cmd, 0);
            tick(); tick();
            pulse_conv_done();
            check("R4 conv bit cleared", ctrl_word[4], 0);
        end
        check("R7 idle at end", busy, 0);
    endtask

    initial begin
        for (int w = 0; w < 100000; w++) begin
            @(posedge clk);
            if (finished) break;
        end
        if (!finished) begin
            n_fail++;
            $display("FAIL watchdog: actual hung expected done");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        bit seen;
        logic [13:0] d;
        logic [13:0] snap;
        rst_n = 1'b0; wr_en = 1'b0; wr_addr = '0; wr_data = '0;
        read_done = 1'b0; conv_done = 1'b0; step_done = 1'b0;
        repeat (3) tick();
        rst_n = 1'b1;
        tick();

        check("R2 word zero", ctrl_word, 0);
        check("R2 busy low", busy, 0);
        check("R2 err low", wr_err, 0);
        check("R2 no step", step_cmd, 0);
        check("R2 no conv", conv_start, 0);
        check("R2 coef valid", coef_sel_valid, 1);

        // R3 sweep of every non-start field, R8 coefficient address
        for (int pm = 0; pm < 4; pm++)
            for (int rs = 0; rs < 4; rs++)
                for (int im = 0; im < 2; im++)
                    for (int cm = 0; cm < 2; cm++)
                        for (int ct = 0; ct < 4; ct++) begin
                            d = 14'((pm << 8) | (rs << 6) | (im << 5) | (cm << 3) | (ct << 1));
                            write(2'b11, d);
                            check("R3 word", ctrl_word, d);
                            check("R3 pwr", pwr_mode, pm);
                            check("R3 rsel", rd_sel, rs);
                            check("R3 imode", if_mode1, im);
                            check("R8 coef addr", coef_sel, ct);
                            check("R8 coef valid", coef_sel_valid, 1);
                            check("R3 no busy", busy, 0);
                        end

        // R1 off-address writes
        write(2'b11, 14'h0124);
        snap = ctrl_word;
        for (int a = 0; a < 3; a++) begin
            write(2'(a), 14'h3FFF);
            check("R1 off-address ignored", ctrl_word, snap);
            check("R1 no activity", busy, 0);
        end

        // R5 read_done clears mode, write wins in same cycle
        write(2'b11, 14'h0020);
        check("R5 mode set", if_mode1, 1);
        read_done = 1'b1; tick(); read_done = 1'b0;
        check("R5 cleared by read", if_mode1, 0);
        read_done = 1'b1; write(2'b11, 14'h0020); read_done = 1'b0;
        check("R5 write wins", if_mode1, 1);
        read_done = 1'b1; tick(); read_done = 1'b0;

        // R4 conversion and R9 busy ignore
        write(2'b11, 14'h0010);
        check("R4 bit set", ctrl_word[4], 1);
        wait_conv(seen);
        check("R4 conv pulse", seen, 1);
        tick();
        check("R12 conv one cycle", conv_start, 0);
        check("R4 busy in conv", busy, 1);
        write(2'b11, 14'h0001);
        check("R9 cal start ignored", ctrl_word[0], 0);
        write(2'b11, 14'h00C0);
        check("R9 conv bit kept", ctrl_word[4], 1);
        check("R9 other field taken", rd_sel, 3);
        pulse_conv_done();
        check("R4 bit cleared", ctrl_word[4], 0);
        check("R4 busy dropped", busy, 0);
        for (int k = 0; k < 6; k++) begin
            check("R9 no late step", step_cmd, 0);
            check("R9 no second conv", conv_start, 0);
            tick();
        end

        // R6/R7 all eight calibration choices
        for (int md = 0; md < 2; md++)
            for (int ty = 0; ty < 4; ty++)
                run_cal(md, ty, 1'b0);

        // R10 both start bits
        run_cal(1, 0, 1'b1);
        run_cal(0, 2, 1'b1);

        // R11 reserved bits
        write(2'b11, 14'h2C80);
        check("R11 err set", wr_err, 1);
        check("R11 rest accepted", rd_sel, 2);
        check("R11 reserved read zero", ctrl_word[13:10], 0);
        write(2'b11, 14'h0000);
        check("R11 err sticky", wr_err, 1);

        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule